// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block produces the reset that clears the CPU core of a small 8-bit controller, and the level driven onto the reset-output pin. The level that reaches the pin is the same signal that resets the CPU. Two sources can cause a reset. The first is an external reset level that has already been debounced. It counts only after it has stayed high for a minimum time. The second is a one-cycle overflow strobe from the watchdog. It becomes a short reset pulse of fixed length.

A machine cycle is twelve system clocks, and a free-running divider marks the last clock of each one. The minimum width of the external reset depends on the clock source. On the high-frequency oscillator it is two machine cycles. On the PLL clock it is a time in microseconds, converted into clocks from the PLL frequency parameter. While any reset is active, the block also forces the address-latch strobe and the program-store strobe high.

The controller is a four-state machine. `ST_POR` holds reset from power-up until the first decision. `ST_IDLE` means no reset. `ST_EXT` is a qualified external reset. `ST_WDT` is a watchdog pulse. The named transitions are:
- `por_to_ext` and `idle_to_ext`: the input qualifies.
- `por_release`: the input is low on the first machine-cycle boundary.
- `por_to_wdt` and `idle_to_wdt`: the watchdog pulse is running.
- `ext_release` and `ext_to_wdt`: the input is low on a machine-cycle boundary, and the pulse is either finished or still running.
- `wdt_to_ext`: the input qualifies during a pulse.
- `wdt_release`: the pulse ends.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `por_n` is released, all four outputs stay high until the first machine-cycle boundary. They then fall if the reset input is low.
- R2: With `pll_sel` low, a reset input high for 24 or more consecutive clocks asserts reset. A high pulse of 23 clocks or fewer leaves every output low.
- R3: With `pll_sel` high, the input must stay high for PLL_CLK_MHZ*PLL_MIN_US clocks, which is 96 by default. A pulse one clock shorter leaves every output low.
- R4: A qualified external reset stays high while the input stays high. After the input falls, reset is released on the first machine-cycle boundary once the synchronized input is low. That is 2 to 13 clock samples after the input drop, and successive external releases are a multiple of 12 clocks apart.
- R5: A watchdog strobe seen while no reset is active gives a reset exactly 36 clocks (3 machine cycles) long. It starts on the clock after the strobe is registered.
- R6: A watchdog strobe during a running watchdog pulse restarts the 36-clock count. Two strobes 20 clocks apart give 56 clocks of reset.
- R7: A watchdog strobe during an external reset is absorbed. The output stays high, with no gap, until both sources have released.
- R8: `rst_out`, `ale_hi` and `psen_hi` always equal `cpu_rst`.
- R9: The reset input passes through two synchronizing flops. The width count clears on any clock when the synchronized input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| rst_lvl_i | input | 1 | Debounced external reset level, active high |
| wdt_ovf_i | input | 1 | One-clock watchdog overflow strobe |
| pll_sel_i | input | 1 | Clock source select: 0 high-frequency oscillator, 1 PLL |
| cpu_rst | output | 1 | Internal CPU reset |
| rst_out | output | 1 | Reset-output pin level |
| ale_hi | output | 1 | Forces the address-latch strobe high |
| psen_hi | output | 1 | Forces the program-store strobe high |

## Verification
The hardest case to reach from the ports is a watchdog strobe landing in the last clocks of an external reset. It must fall while the synchronizer still holds the input high, and before the machine-cycle boundary releases `ST_EXT`. The bench raises the strobe on the final clock the input is high and drops the input one clock later. It then counts 37 consecutive high samples with no gap. The release phase of `ST_EXT` is checked by recording the clock count of two external releases and requiring the difference to be a multiple of twelve.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_IDLE = 2'd1,
        ST_EXT  = 2'd2,
        ST_WDT  = 2'd3
    } rst_state_e;
endpackage

// File: rtl/rsc_mc_tick.sv
// Divide-by-MC_DIV counter: tick_o marks the last clock of each machine cycle.
module rsc_mc_tick #(
    parameter int MC_DIV = 12
) (
    input  logic clk,
    input  logic por_n,
    output logic tick_o
);
    localparam int CW = $clog2(MC_DIV);
    localparam logic [CW-1:0] LAST = CW'(MC_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = (div_q == LAST);

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rsc_sync.sv
// Two-flop synchronizer for the reset level.
module rsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) pipe_q[0] <= 1'b0;
                    else        pipe_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) pipe_q[g] <= 1'b0;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rsc_width_qual.sv
// Counts consecutive high clocks of the synchronized level and flags
// when the clock-source dependent minimum width is reached.
module rsc_width_qual #(
    parameter int HF_CYC  = 24,
    parameter int PLL_CYC = 96
) (
    input  logic clk,
    input  logic por_n,
    input  logic lvl_i,
    input  logic pll_sel_i,
    output logic qual_o
);
    localparam int MAXC = (HF_CYC > PLL_CYC) ? HF_CYC : PLL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SAT      = CW'(MAXC);
    localparam logic [CW-1:0] HF_LIM   = CW'(HF_CYC - 1);
    localparam logic [CW-1:0] PLL_LIM  = CW'(PLL_CYC - 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] limit;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q <= '0;
        end else if (!lvl_i) begin
            run_q <= '0;
        end else if (run_q != SAT) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        limit  = pll_sel_i ? PLL_LIM : HF_LIM;
        qual_o = lvl_i && (run_q >= limit);
    end

    // R9
    qual_needs_level_chk: assert property (@(posedge clk) disable iff (!por_n)
        !lvl_i |=> (run_q == '0));
endmodule

// File: rtl/rsc_wdt_pulse.sv
// Stretches a watchdog strobe into a fixed-length pulse; a new strobe reloads.
module rsc_wdt_pulse #(
    parameter int PULSE_CYC = 36
) (
    input  logic clk,
    input  logic por_n,
    input  logic ovf_i,
    output logic active_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            left_q <= '0;
        end else if (ovf_i) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = (left_q != '0);

    // R5
    wdt_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovf_i |=> active_o);
    // R6
    wdt_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovf_i |=> (left_q == LOAD));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int MC_DIV      = 12,
    parameter int HF_MIN_MC   = 2,
    parameter int PLL_CLK_MHZ = 96,
    parameter int PLL_MIN_US  = 1,
    parameter int WDT_MC      = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_lvl_i,
    input  logic wdt_ovf_i,
    input  logic pll_sel_i,
    output logic cpu_rst,
    output logic rst_out,
    output logic ale_hi,
    output logic psen_hi
);
    import rsc_pkg::*;

    localparam int HF_CYC    = HF_MIN_MC * MC_DIV;
    localparam int PLL_CYC   = PLL_CLK_MHZ * PLL_MIN_US;
    localparam int PULSE_CYC = WDT_MC * MC_DIV;

    logic       mc_tick;
    logic       lvl_sync;
    logic       ext_qual;
    logic       wdt_act;
    rst_state_e state_q;
    rst_state_e state_d;
    logic       rst_any;

    rsc_mc_tick #(.MC_DIV(MC_DIV)) u_tick (
        .clk(clk), .por_n(por_n), .tick_o(mc_tick)
    );

    rsc_sync #(.STAGES(2)) u_sync (
        .clk(clk), .por_n(por_n), .d_i(rst_lvl_i), .q_o(lvl_sync)
    );

    rsc_width_qual #(.HF_CYC(HF_CYC), .PLL_CYC(PLL_CYC)) u_qual (
        .clk(clk), .por_n(por_n), .lvl_i(lvl_sync),
        .pll_sel_i(pll_sel_i), .qual_o(ext_qual)
    );

    rsc_wdt_pulse #(.PULSE_CYC(PULSE_CYC)) u_wdt (
        .clk(clk), .por_n(por_n), .ovf_i(wdt_ovf_i), .active_o(wdt_act)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_POR;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR: begin
                if (ext_qual)                        state_d = ST_EXT;   // por_to_ext
                else if (wdt_act)                    state_d = ST_WDT;   // por_to_wdt
                else if (mc_tick && !lvl_sync)       state_d = ST_IDLE;  // por_release
            end
            ST_IDLE: begin
                if (ext_qual)                        state_d = ST_EXT;   // idle_to_ext
                else if (wdt_act)                    state_d = ST_WDT;   // idle_to_wdt
            end
            ST_EXT: begin
                if (mc_tick && !lvl_sync) begin
                    if (wdt_act)                     state_d = ST_WDT;   // ext_to_wdt
                    else                             state_d = ST_IDLE;  // ext_release
                end
            end
            ST_WDT: begin
                if (ext_qual)                        state_d = ST_EXT;   // wdt_to_ext
                else if (!wdt_act)                   state_d = ST_IDLE;  // wdt_release
            end
            default:                                 state_d = ST_POR;
        endcase
    end

    // output decode
    always_comb begin
        rst_any = (state_q != ST_IDLE);
        cpu_rst = rst_any;
        rst_out = rst_any;
        ale_hi  = rst_any;
        psen_hi = rst_any;
    end

    // R2
    qual_to_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        ext_qual |=> cpu_rst);

    // R4
    ext_release_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(cpu_rst) && $past(state_q == ST_EXT)) |-> ($past(mc_tick) && !$past(lvl_sync)));

    // R1
    por_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_POR && !mc_tick) |=> cpu_rst);

    // R7
    wdt_keeps_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_act |=> cpu_rst);
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_lvl_i = 1'b0;
    logic wdt_ovf_i = 1'b0;
    logic pll_sel_i = 1'b0;
    logic cpu_rst, rst_out, ale_hi, psen_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rel_a = 0;
    int rel_b = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_seq_ctrl dut_i (
        .clk(clk), .por_n(por_n), .rst_lvl_i(rst_lvl_i), .wdt_ovf_i(wdt_ovf_i),
        .pll_sel_i(pll_sel_i), .cpu_rst(cpu_rst), .rst_out(rst_out),
        .ale_hi(ale_hi), .psen_hi(psen_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_mirror(input string req);
        check(req, int'({rst_out, ale_hi, psen_hi}), cpu_rst ? 7 : 0);
    endtask

    // Apply a reset pulse of len clocks; return how many samples saw reset.
    task automatic pulse(input int len, output int seen);
        seen = 0;
        @(negedge clk) rst_lvl_i = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (cpu_rst) seen++;
        end
        rst_lvl_i = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cpu_rst) seen++;
        end
    endtask

    // Hold input high long, drop it, count samples until release; record release time.
    task automatic ext_release(output int highs, output int rel_cyc);
        highs = 0;
        rel_cyc = 0;
        @(negedge clk) rst_lvl_i = 1'b1;
        repeat (40) @(negedge clk);
        rst_lvl_i = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cpu_rst) highs++;
            else if (rel_cyc == 0) rel_cyc = cyc;
        end
    endtask

    task automatic t_powerup();
        @(negedge clk);
        check("R1 held in por", int'(cpu_rst), 1);
        check_mirror("R8 por");
        por_n = 1'b1;
        @(negedge clk);
        check("R1 held after por release", int'(cpu_rst), 1);
        repeat (14) @(negedge clk);
        check("R1 released after first boundary", int'(cpu_rst), 0);
        check_mirror("R8 idle");
    endtask

    task automatic t_hf_width();
        int seen;
        pll_sel_i = 1'b0;
        pulse(23, seen);
        check("R2 23-clock pulse ignored", seen, 0);
        pulse(24, seen);
        check("R2 24-clock pulse qualifies", int'(seen > 0), 1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_pll_width();
        int seen;
        pll_sel_i = 1'b1;
        pulse(95, seen);
        check("R3 95-clock pulse ignored", seen, 0);
        pulse(96, seen);
        check("R3 96-clock pulse qualifies", int'(seen > 0), 1);
        pll_sel_i = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_release();
        int h;
        ext_release(h, rel_a);
        check("R4 release not before sync", int'(h >= 2), 1);
        check("R4 release within a machine cycle", int'(h <= 13), 1);
        repeat (7) @(negedge clk);
        ext_release(h, rel_b);
        check("R4 release phase multiple of 12", (rel_b - rel_a) % 12, 0);
        check_mirror("R8 after release");
    endtask

    task automatic count_after_strobe(input int gap, output int highs);
        highs = 0;
        @(negedge clk) wdt_ovf_i = 1'b1;
        @(negedge clk) wdt_ovf_i = 1'b0;
        for (int i = 0; i < 90; i++) begin
            if (gap > 0 && i == gap - 1) wdt_ovf_i = 1'b1;
            if (gap > 0 && i == gap) wdt_ovf_i = 1'b0;
            if (cpu_rst) highs++;
            if (i == 10) check_mirror("R8 wdt pulse");
            @(negedge clk);
        end
    endtask

    task automatic t_wdt_single();
        int h;
        count_after_strobe(0, h);
        check("R5 watchdog pulse length", h, 36);
    endtask

    task automatic t_wdt_restart();
        int h;
        count_after_strobe(20, h);
        check("R6 restarted pulse length", h, 56);
    endtask

    task automatic t_wdt_in_ext();
        int h;
        int gap;
        bit ended;
        h = 0; gap = 0; ended = 0;
        @(negedge clk) rst_lvl_i = 1'b1;
        repeat (30) @(negedge clk);
        wdt_ovf_i = 1'b1;
        @(negedge clk);
        wdt_ovf_i = 1'b0;
        rst_lvl_i = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (cpu_rst) begin
                h++;
                if (ended) gap = 1;
            end else begin
                ended = 1;
            end
            @(negedge clk);
        end
        check("R7 merged reset length", h, 37);
        check("R7 no gap in merged reset", gap, 0);
        // early strobe expires inside external reset: release follows input
        @(negedge clk) rst_lvl_i = 1'b1;
        repeat (30) @(negedge clk);
        wdt_ovf_i = 1'b1;
        @(negedge clk) wdt_ovf_i = 1'b0;
        repeat (60) @(negedge clk);
        check("R7 reset held by input after pulse", int'(cpu_rst), 1);
        rst_lvl_i = 1'b0;
        repeat (15) @(negedge clk);
        check("R7 release after both sources", int'(cpu_rst), 0);
    endtask

    initial begin
        t_powerup();
        t_hf_width();
        t_pll_width();
        t_release();
        t_wdt_single();
        t_wdt_restart();
        t_wdt_in_ext();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule